// File: doc/BRIEF.md
# Framed Word Serializer with Selectable Capture Edge

This block turns a parallel data word into a serial bit stream on a bit clock that runs twelve times faster than a slower reference clock. The reference clock arrives as an ordinary input. It is oversampled on the bit clock, and either its rising or its falling edge is picked out, depending on a select input. On each selected edge the parallel word is latched into a holding register. The word then leaves the block as a 12-bit frame: a high start bit, the ten data bits least significant first, and a low stop bit. The fixed start and stop bits guarantee at least one line transition in every frame.

A new frame is loaded only when the current one has finished. The stream therefore carries exactly one frame per reference period and never cuts a frame short. The block has three modes, which it passes through in order. In initialization it waits for a lock indication. In synchronization it sends a fixed number of sync frames, each made of six ones followed by six zeros. In data mode it sends framed words. While in data mode, a sync-insert request can replace whole frames with the sync pattern.

The output-valid flag stands in for the line's high-impedance control. It is low while the block is disabled, while it is powered down, and while it is in initialization.

Top module: `framed_word_serializer`

## Requirements
- R1: A data frame is 12 bit-clock cycles long. On `ser_out` it shows the start bit (1) in its first cycle, then `data_in` bits 0 to 9 in that order, then the stop bit (0) in its last cycle.
- R2: With `edge_sel` high, the word sent is the one present on `data_in` shortly after a rising edge of `ref_clk`.
- R3: With `edge_sel` low, the word sent is the one present on `data_in` shortly after a falling edge of `ref_clk`.
- R4: When `ref_clk` has a period of exactly 12 bit clocks, consecutive data frames carry consecutive captured words, with none dropped, repeated or truncated.
- R5: While `tx_en` is low, `out_valid` is low in that same cycle. The framing and word sequence on `ser_out` keep running unchanged.
- R6: While `pwr_n` is low, `out_valid` and `ser_out` are low and the block returns to initialization. After `pwr_n` rises, the block starts again with the synchronization mode.
- R7: `out_valid` stays low until `lock` is high. If `lock` goes low, `out_valid` is low from the next cycle, and the block restarts from initialization.
- R8: After lock, `out_valid` rises at the start of a frame, and exactly SYNC_FRAMES sync frames (4 by default) follow. A sync frame is ones in its first six cycles and zeros in its last six. Data frames follow the sync frames.
- R9: In data mode, `sync_req` is sampled at each frame boundary. Every frame that starts while it is high is a sync frame. After it drops, data frames resume, and the word sequence continues as if the sync frames had replaced data frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 12 times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock, sampled on `clk` |
| edge_sel | input | 1 | 1 selects rising-edge capture, 0 selects falling-edge capture |
| data_in | input | 10 | Parallel data word |
| tx_en | input | 1 | Output enable, active high |
| pwr_n | input | 1 | Power-down, active low |
| lock | input | 1 | Lock indication from the clock controller |
| sync_req | input | 1 | Request to send sync frames |
| ser_out | output | 1 | Serial line bit |
| out_valid | output | 1 | Line driven (low means high impedance) |

## Verification
The hardest case to set up is a sync request that lands on a known frame boundary while data is flowing. Checking it also means proving that the word sequence picks up correctly once the request is released. The bench builds `ref_clk` from a counter on the bit clock, so the reference period is exactly twelve cycles. It uses the rise of `out_valid` as its frame-alignment point. With that alignment, the bench can raise and drop `sync_req` in the middle of chosen frames. Each data word carries an edge marker and a running index, so the bench can tell which edge captured a word and whether any word was skipped.

// File: rtl/framed_word_serializer.sv
module framed_word_serializer #(
  parameter int DATA_W      = 10,
  parameter int SYNC_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              edge_sel,
  input  logic [DATA_W-1:0] data_in,
  input  logic              tx_en,
  input  logic              pwr_n,
  input  logic              lock,
  input  logic              sync_req,
  output logic              ser_out,
  output logic              out_valid
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int SC_W    = $clog2(SYNC_FRAMES + 1);
  localparam int HALF    = FRAME_W / 2;
  localparam logic [CNT_W-1:0]   LAST     = CNT_W'(FRAME_W - 1);
  localparam logic [FRAME_W-1:0] SYNC_PAT = {FRAME_W{1'b1}} >> (FRAME_W - HALF);

  typedef enum logic [1:0] {M_INIT, M_SYNC, M_DATA} mode_t;

  mode_t              mode, mode_n;
  logic [2:0]         ref_q;
  logic [DATA_W-1:0]  hold;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;
  logic [SC_W-1:0]    scnt, scnt_n;
  logic               frm_sync, send_sync;

  wire wrap    = (cnt == LAST);
  wire ref_hit = edge_sel ? (ref_q[1] & ~ref_q[2]) : (~ref_q[1] & ref_q[2]);

  always_comb begin
    mode_n    = mode;
    scnt_n    = scnt;
    send_sync = 1'b0;
    if (!lock) begin
      mode_n = M_INIT;
    end else if (wrap) begin
      case (mode)
        M_INIT: begin
          mode_n    = M_SYNC;
          send_sync = 1'b1;
          scnt_n    = SC_W'(1);
        end
        M_SYNC: begin
          if (scnt >= SC_W'(SYNC_FRAMES)) begin
            mode_n    = M_DATA;
            send_sync = sync_req;
          end else begin
            send_sync = 1'b1;
            scnt_n    = scnt + 1'b1;
          end
        end
        default: send_sync = sync_req;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_INIT;
      ref_q    <= '0;
      hold     <= '0;
      sh       <= '0;
      cnt      <= LAST;
      scnt     <= '0;
      frm_sync <= 1'b0;
    end else if (!pwr_n) begin
      mode     <= M_INIT;
      ref_q    <= '0;
      hold     <= '0;
      sh       <= '0;
      cnt      <= LAST;
      scnt     <= '0;
      frm_sync <= 1'b0;
    end else begin
      ref_q <= {ref_q[1:0], ref_clk};
      if (ref_hit) hold <= data_in;
      mode <= mode_n;
      scnt <= scnt_n;
      if (wrap) begin
        cnt      <= '0;
        frm_sync <= send_sync;
        sh       <= send_sync ? SYNC_PAT : {1'b0, hold, 1'b1};
      end else begin
        cnt <= cnt + 1'b1;
        sh  <= sh >> 1;
      end
    end
  end

  assign ser_out   = sh[0];
  assign out_valid = tx_en & pwr_n & (mode != M_INIT);

  assert_start_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !frm_sync) |-> ser_out);
  assert_stop_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !frm_sync) |-> !ser_out);
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && !wrap) |=> (cnt == $past(cnt) + 1'b1));
  assert_pwrdn_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> (wrap && mode == M_INIT && !out_valid));
  assert_lock_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> !out_valid);
  assert_sync_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DATA && $past(mode) == M_SYNC) |-> ($past(scnt) == SC_W'(SYNC_FRAMES)));
  assert_sync_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SYNC) |-> frm_sync);
endmodule

// File: tb/test_framed_word_serializer.sv
module test_framed_word_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       edge_sel = 1'b1;
  logic [9:0] data_in = '0;
  logic       tx_en = 1'b0;
  logic       pwr_n = 1'b1;
  logic       lock = 1'b0;
  logic       sync_req = 1'b0;
  logic       ser_out, out_valid;

  int total = 0;
  int fails = 0;
  logic [7:0] k = '0;
  logic [7:0] prev_idx = '0;
  bit         have_prev = 0;
  localparam logic [11:0] SYNC_F = 12'h03F;

  always #2 clk = ~clk;

  framed_word_serializer i_framed_word_serializer (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .edge_sel(edge_sel),
    .data_in(data_in), .tx_en(tx_en), .pwr_n(pwr_n), .lock(lock),
    .sync_req(sync_req), .ser_out(ser_out), .out_valid(out_valid));

  // reference clock of exactly 12 bit clocks; word marks edge (bit 9) and index
  initial begin
    forever begin
      for (int rc = 0; rc < 12; rc++) begin
        @(negedge clk);
        if (rc == 0) begin
          k       = k + 1'b1;
          ref_clk = 1'b1;
          data_in = {2'b01, k};
        end else if (rc == 6) begin
          ref_clk = 1'b0;
          data_in = {2'b11, k};
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic get_frame(output logic [11:0] f, input bit drv, input bit val);
    for (int i = 0; i < 12; i++) begin
      f[i] = ser_out;
      if (drv && i == 5) sync_req = val;
      @(negedge clk);
    end
  endtask

  task automatic wait_valid(input string req);
    for (int i = 0; i < 200 && !out_valid; i++) @(negedge clk);
    check(out_valid, req, out_valid, 1);
  endtask

  task automatic check_data(input int n, input bit b9, input string edge_req);
    logic [11:0] f;
    for (int j = 0; j < n; j++) begin
      get_frame(f, 0, 0);
      check(f[0] == 1'b1, "R1 start", f, 1);
      check(f[11] == 1'b0, "R1 stop", f, 0);
      check(f[9] == 1'b1, "R1 bit order", f[10:1], 10'h100);
      check(f[10] == b9, edge_req, f[10:1], {b9, 9'h100});
      if (have_prev) check(f[8:1] == prev_idx + 1'b1, "R4", f[8:1], prev_idx + 1'b1);
      prev_idx  = f[8:1];
      have_prev = 1;
    end
  endtask

  task automatic check_sync_seq(input string req);
    logic [11:0] f;
    for (int j = 0; j < 4; j++) begin
      get_frame(f, 0, 0);
      check(f == SYNC_F, req, f, SYNC_F);
    end
    have_prev = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!out_valid && !ser_out, "R7 reset", {out_valid, ser_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R7 after reset", out_valid, 0);
  endtask

  task automatic t_init_hold;
    int seen = 0;
    tx_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    check(seen == 0, "R7 no lock", seen, 0);
  endtask

  task automatic t_lock_up;
    lock = 1'b1;
    wait_valid("R8 valid after lock");
    check_sync_seq("R8 sync frame");
    check_data(6, 1'b0, "R2 rising capture");
  endtask

  task automatic t_enable;
    tx_en = 1'b0;
    #1;
    check(!out_valid, "R5 disable", out_valid, 0);
    check_data(2, 1'b0, "R5 stream runs");
    check(!out_valid, "R5 still disabled", out_valid, 0);
    tx_en = 1'b1;
    #1;
    check(out_valid, "R5 re-enable", out_valid, 1);
    check_data(2, 1'b0, "R5 continuity");
  endtask

  task automatic t_sync_req;
    logic [11:0] f;
    get_frame(f, 1, 1);
    check(f != SYNC_F && f[0], "R9 frame before", f, 0);
    prev_idx = f[8:1];
    get_frame(f, 0, 0);
    check(f == SYNC_F, "R9 inserted 1", f, SYNC_F);
    get_frame(f, 0, 0);
    check(f == SYNC_F, "R9 inserted 2", f, SYNC_F);
    get_frame(f, 1, 0);
    check(f == SYNC_F, "R9 inserted 3", f, SYNC_F);
    get_frame(f, 0, 0);
    check(f[0] && !f[11], "R9 data resumes", f, 1);
    check(f[8:1] == prev_idx + 8'd4, "R9 sequence", f[8:1], prev_idx + 8'd4);
    prev_idx = f[8:1];
  endtask

  task automatic t_lock_loss;
    int seen = 0;
    lock = 1'b0;
    @(negedge clk);
    check(!out_valid, "R7 lock loss", out_valid, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    check(seen == 0, "R7 stays off", seen, 0);
    lock = 1'b1;
    wait_valid("R7 relock");
    check_sync_seq("R7 resync");
    check_data(3, 1'b0, "R2 after relock");
  endtask

  task automatic t_powerdown_fall;
    pwr_n    = 1'b0;
    edge_sel = 1'b0;
    #1;
    check(!out_valid, "R6 off now", out_valid, 0);
    repeat (20) @(negedge clk);
    check(!out_valid && !ser_out, "R6 idle", {out_valid, ser_out}, 0);
    pwr_n = 1'b1;
    wait_valid("R6 wake");
    check_sync_seq("R6 resync");
    check_data(6, 1'b1, "R3 falling capture");
  endtask

  initial begin
    t_reset();
    t_init_hold();
    t_lock_up();
    t_enable();
    t_sync_req();
    t_lock_loss();
    t_powerdown_fall();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule